// File: doc/BRIEF.md
# Memory Type Range Resolver

This block answers one question per request: which cache memory type applies to a given physical address. Software programs a small set of configuration registers through a write port. These are a default-type register with two enable bits, a table of type bytes that covers the first megabyte at three granularities, an optional upper-memory boundary, and a parameterised bank of variable ranges. Each variable range is described by a base/mask pair. A lookup presents an address with a valid strobe. One clock later the block returns an 8-bit type code with a valid flag.

All variable ranges are compared against the address in parallel. When several ranges claim the same address, their types are combined in a balanced reduction tree using fixed precedence rules, so the result does not depend on which range slot holds which entry. Below one megabyte, when the fixed table is enabled, the table alone decides the type. Above four gigabytes, an address below the upper-memory boundary is promoted to write-back.

Top module: `mtr_resolver`

## Requirements
- R1: `rspValid` is high exactly in the cycle after a cycle with `reqValid` high. While no request is made, `rspType` holds its last value.
- R2: With both enable bits of the default register clear, every lookup returns 8'hFF. The default register is selector 8'h00, with bit 10 as the fixed-table enable, bit 11 as the variable-range enable and bits 7:0 as the default type.
- R3: A register write takes effect on the clock edge that samples it. A lookup in that same cycle returns a result computed from the previous contents.
- R4: With the fixed table enabled and the address below 0x100000, only the fixed table decides the type. The index is computed as follows:
  - Below 0x80000, the entry is address bits 18:16.
  - From 0x80000 to 0xBFFFF, the entry is 8 plus address bits 17:14.
  - From 0xC0000 upward, the entry is 24 plus address bits 17:12.
  - Table word w is written at selector 8'h10+w (w = 0..10), and byte k of the word holds entry 8w+k.
- R5: With the fixed table disabled, or at or above 0x100000, the fixed table is not consulted.
- R6: Variable range i has its base at selector 8'h20+2i and its mask at 8'h21+2i.
  - The type is in base bits 7:0, and the valid flag is mask bit 11.
  - A valid range hits when address and base agree on every bit 35:12 set in the mask.
  - Bits 11:0 of base and mask play no part in matching, and an invalid range never hits.
- R7: Type codes are uncacheable 0, write-combining 1, write-through 4, write-protect 5 and write-back 6. When several ranges hit, the result is merged as follows:
  - Any uncacheable hit gives uncacheable.
  - A mix of write-back and write-through gives write-through.
  - Identical types keep that type.
  - Any other mix gives uncacheable.
- R8: With the variable ranges disabled, or with no range hitting, the default type is returned.
- R9: The boundary register is selector 8'h01 and keeps only bits 35:23 of the written value. The promotion applies when all of the following hold:
  - the boundary is nonzero;
  - variable ranges are enabled;
  - the address is at or above 4 GiB and below the boundary.

  Such an address resolves to write-back, unless two or more ranges hit and merge to uncacheable.
- R10: After reset all registers are zero, `rspValid` is low, and lookups return 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 8 | Register selector |
| wrData | input | 64 | Register write data |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | 36 | Physical address to resolve |
| rspValid | output | 1 | Result valid, one cycle after request |
| rspType | output | 8 | Resolved type code, or 8'hFF when disabled |

## Verification
The checker assumes that every type byte software writes is one of the five legal codes. Under that assumption, every result is either a legal code or 8'hFF, and 8'hFF appears only while both enables are clear. The checker tracks the enable bits by watching writes to selector 8'h00 at the ports. It therefore also assumes that those bits change through no other path. The directed stimulus writes only legal type codes, including in the fixed table. Where the bench puts unrelated bits into base, mask or boundary words, it places them only in fields that the requirements declare ignored.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

  localparam logic [7:0] MT_UC  = 8'h00;
  localparam logic [7:0] MT_WC  = 8'h01;
  localparam logic [7:0] MT_WT  = 8'h04;
  localparam logic [7:0] MT_WP  = 8'h05;
  localparam logic [7:0] MT_WB  = 8'h06;
  localparam logic [7:0] MT_OFF = 8'hFF;

  localparam int IDX_W = 5;

  // one node of the precedence reduction tree
  typedef struct packed {
    logic       hit;
    logic       multi;
    logic [7:0] kind;
  } hitNode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             defWr;
    logic             tomWr;
    logic             fixWr;
    logic             varWr;
    logic             varMask;
    logic [IDX_W-1:0] idx;
    logic             capture;
  } cfgStrobe_t;

  function automatic hitNode_t mergeNodes(input hitNode_t a, input hitNode_t b);
    hitNode_t r;
    if (!a.hit) begin
      r = b;
    end else if (!b.hit) begin
      r = a;
    end else begin
      r.hit   = 1'b1;
      r.multi = 1'b1;
      if (a.kind == MT_UC || b.kind == MT_UC)
        r.kind = MT_UC;
      else if (a.kind == b.kind)
        r.kind = a.kind;
      else if ((a.kind == MT_WB && b.kind == MT_WT) || (a.kind == MT_WT && b.kind == MT_WB))
        r.kind = MT_WT;
      else
        r.kind = MT_UC;
    end
    return r;
  endfunction

endpackage

// File: rtl/mtr_ctrl.sv
module mtr_ctrl
  import mtr_pkg::*;
#(
  parameter int NUM_VAR   = 8,
  parameter int FIX_WORDS = 11,
  parameter int SEL_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic             reqValid,
  output cfgStrobe_t       strobe,
  output logic             rspValid
);

  localparam logic [SEL_W-1:0] SEL_DEF = SEL_W'(8'h00);
  localparam logic [SEL_W-1:0] SEL_TOM = SEL_W'(8'h01);
  localparam logic [SEL_W-1:0] SEL_FIX = SEL_W'(8'h10);
  localparam logic [SEL_W-1:0] SEL_VAR = SEL_W'(8'h20);
  localparam logic [SEL_W-1:0] FIX_END = SEL_FIX + SEL_W'(FIX_WORDS);
  localparam logic [SEL_W-1:0] VAR_END = SEL_VAR + SEL_W'(2 * NUM_VAR);

  logic [SEL_W-1:0] fixOff;
  logic [SEL_W-1:0] varOff;

  assign fixOff = wrSel - SEL_FIX;
  assign varOff = wrSel - SEL_VAR;

  always_comb begin
    strobe         = '0;
    strobe.capture = reqValid;
    if (wrEn) begin
      if (wrSel == SEL_DEF) begin
        strobe.defWr = 1'b1;
      end else if (wrSel == SEL_TOM) begin
        strobe.tomWr = 1'b1;
      end else if (wrSel >= SEL_FIX && wrSel < FIX_END) begin
        strobe.fixWr = 1'b1;
        strobe.idx   = fixOff[IDX_W-1:0];
      end else if (wrSel >= SEL_VAR && wrSel < VAR_END) begin
        strobe.varWr   = 1'b1;
        strobe.varMask = varOff[0];
        strobe.idx     = varOff[IDX_W:1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

endmodule

// File: rtl/mtr_dpath.sv
module mtr_dpath
  import mtr_pkg::*;
#(
  parameter int ADDR_W  = 36,
  parameter int DATA_W  = 64,
  parameter int NUM_VAR = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        rspType
);

  localparam int PAGE_LSB    = 12;
  localparam int TOM_LSB     = 23;
  localparam int FIX_ENTRIES = 88;
  localparam int NODES       = 2 * NUM_VAR - 1;

  // configuration state
  logic [7:0]                    defKind;
  logic                          fixEn;
  logic                          varEn;
  logic [ADDR_W-1:TOM_LSB]       tomHi;
  logic [FIX_ENTRIES-1:0][7:0]   fixTab;
  logic [NUM_VAR-1:0][7:0]       varKind;
  logic [NUM_VAR-1:0][ADDR_W-1:PAGE_LSB] varBase;
  logic [NUM_VAR-1:0][ADDR_W-1:PAGE_LSB] varMaskBits;
  logic [NUM_VAR-1:0]            varValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      defKind <= '0;
      fixEn   <= 1'b0;
      varEn   <= 1'b0;
      tomHi   <= '0;
    end else begin
      if (strobe.defWr) begin
        defKind <= wrData[7:0];
        fixEn   <= wrData[10];
        varEn   <= wrData[11];
      end
      if (strobe.tomWr) tomHi <= wrData[ADDR_W-1:TOM_LSB];
    end
  end

  for (genvar e = 0; e < FIX_ENTRIES; e++) begin : g_fix
    always_ff @(posedge clk) begin
      if (!rstN)
        fixTab[e] <= '0;
      else if (strobe.fixWr && strobe.idx == IDX_W'(e / 8))
        fixTab[e] <= wrData[8*(e%8) +: 8];
    end
  end

  for (genvar i = 0; i < NUM_VAR; i++) begin : g_var
    always_ff @(posedge clk) begin
      if (!rstN) begin
        varKind[i]     <= '0;
        varBase[i]     <= '0;
        varMaskBits[i] <= '0;
        varValid[i]    <= 1'b0;
      end else if (strobe.varWr && strobe.idx == IDX_W'(i)) begin
        if (strobe.varMask) begin
          varMaskBits[i] <= wrData[ADDR_W-1:PAGE_LSB];
          varValid[i]    <= wrData[11];
        end else begin
          varKind[i] <= wrData[7:0];
          varBase[i] <= wrData[ADDR_W-1:PAGE_LSB];
        end
      end
    end
  end

  // fixed-table index, three granularities
  logic       lowMeg;
  logic [6:0] fixIdx;
  logic [7:0] fixKind;

  assign lowMeg = (reqAddr[ADDR_W-1:20] == '0);

  always_comb begin
    if (!reqAddr[19])      fixIdx = {4'd0, reqAddr[18:16]};
    else if (!reqAddr[18]) fixIdx = 7'd8 + {3'd0, reqAddr[17:14]};
    else                   fixIdx = 7'd24 + {1'b0, reqAddr[17:12]};
  end

  assign fixKind = fixTab[fixIdx];

  // variable-range compare and precedence tree
  hitNode_t node [NODES];

  for (genvar i = 0; i < NUM_VAR; i++) begin : g_leaf
    logic [ADDR_W-1:PAGE_LSB] diff;
    assign diff                  = (reqAddr[ADDR_W-1:PAGE_LSB] ^ varBase[i]) & varMaskBits[i];
    assign node[NUM_VAR-1+i].hit   = varValid[i] && (diff == '0);
    assign node[NUM_VAR-1+i].multi = 1'b0;
    assign node[NUM_VAR-1+i].kind  = varKind[i];
  end

  for (genvar n = 0; n < NUM_VAR - 1; n++) begin : g_tree
    assign node[n] = mergeNodes(node[2*n+1], node[2*n+2]);
  end

  // upper-memory promotion
  logic above4G;
  logic tomHit;
  logic conflict;

  assign above4G  = |reqAddr[ADDR_W-1:32];
  assign tomHit   = (|tomHi) && above4G && (reqAddr < {tomHi, {TOM_LSB{1'b0}}});
  assign conflict = node[0].hit && node[0].multi && (node[0].kind == MT_UC);

  logic [7:0] nextType;

  always_comb begin
    if (!fixEn && !varEn)             nextType = MT_OFF;
    else if (fixEn && lowMeg)         nextType = fixKind;
    else if (!varEn)                  nextType = defKind;
    else if (tomHit && !conflict)     nextType = MT_WB;
    else if (node[0].hit)             nextType = node[0].kind;
    else                              nextType = defKind;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rspType <= '0;
    else if (strobe.capture) rspType <= nextType;
  end

endmodule

// File: rtl/mtr_resolver.sv
module mtr_resolver
  import mtr_pkg::*;
#(
  parameter int ADDR_W  = 36,
  parameter int DATA_W  = 64,
  parameter int SEL_W   = 8,
  parameter int NUM_VAR = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [7:0]        rspType
);

  localparam int FIX_WORDS = 11;

  cfgStrobe_t strobe;

  mtr_ctrl #(
    .NUM_VAR  (NUM_VAR),
    .FIX_WORDS(FIX_WORDS),
    .SEL_W    (SEL_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .reqValid(reqValid),
    .strobe  (strobe),
    .rspValid(rspValid)
  );

  mtr_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_VAR(NUM_VAR)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .reqAddr(reqAddr),
    .rspType(rspType)
  );

endmodule

// File: rtl/mtr_checker.sv
module mtr_checker #(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 64,
  parameter int SEL_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [SEL_W-1:0]  wrSel,
  input logic [DATA_W-1:0] wrData,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic [7:0]        rspType
);

  // enable bits as last written at the ports
  logic [1:0] shEn;

  always_ff @(posedge clk) begin
    if (!rstN)                              shEn <= 2'b00;
    else if (wrEn && wrSel == SEL_W'(8'h00)) shEn <= wrData[11:10];
  end

  p_valid_follows_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_hold_type_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(rspType));

  p_off_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && shEn == 2'b00) |=> (rspType == 8'hFF));

  p_on_not_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && shEn != 2'b00) |=> (rspType != 8'hFF));

  p_legal_code_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspType == 8'h00 || rspType == 8'h01 || rspType == 8'h04 ||
                  rspType == 8'h05 || rspType == 8'h06 || rspType == 8'hFF));

  logic unusedAddr;
  assign unusedAddr = ^reqAddr;

endmodule

bind mtr_resolver mtr_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .SEL_W (SEL_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrSel   (wrSel),
  .wrData  (wrData),
  .reqValid(reqValid),
  .reqAddr (reqAddr),
  .rspValid(rspValid),
  .rspType (rspType)
);

// File: tb/mtr_resolver_tb_top.sv
module mtr_resolver_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrSel = '0;
  logic [63:0] wrData = '0;
  logic        reqValid = 1'b0;
  logic [35:0] reqAddr = '0;
  logic        rspValid;
  logic [7:0]  rspType;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mtr_resolver dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .reqValid(reqValid),
    .reqAddr (reqAddr),
    .rspValid(rspValid),
    .rspType (rspType)
  );

  localparam logic [7:0] UC = 8'h00, WC = 8'h01, WT = 8'h04, WP = 8'h05, WB = 8'h06;

  function automatic logic [7:0] fixKind(input int e);
    case (e % 5)
      0: return UC;
      1: return WC;
      2: return WT;
      3: return WP;
      default: return WB;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] sel, input logic [63:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic lookup(input logic [35:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    check({req, " valid"}, 64'(rspValid), 64'd1);
    check({req, " type"}, 64'(rspType), 64'(exp));
  endtask

  task automatic tReset();
    check("R10 rspValid after reset", 64'(rspValid), 64'd0);
    lookup(36'h0, 8'hFF, "R10 R2 lookup after reset");
  endtask

  task automatic tDefaultAndHold();
    writeReg(8'h00, 64'h805);
    lookup(36'h0_0000_1000, WP, "R8 R5 default with no ranges, fixed off");
    @(negedge clk);
    @(negedge clk);
    check("R1 no valid when idle", 64'(rspValid), 64'd0);
    check("R1 type held when idle", 64'(rspType), 64'(WP));
  endtask

  task automatic tFixed();
    for (int w = 0; w < 11; w++) begin
      logic [63:0] d;
      for (int k = 0; k < 8; k++) d[8*k +: 8] = fixKind(8*w + k);
      writeReg(8'h10 + 8'(w), d);
    end
    lookup(36'h0, WP, "R5 fixed table ignored while disabled");
    writeReg(8'h00, 64'hC05);
    lookup(36'h0_0000_0000, fixKind(0),  "R4 first 64K entry");
    lookup(36'h0_0007_FFFF, fixKind(7),  "R4 last 64K entry");
    lookup(36'h0_0008_0000, fixKind(8),  "R4 first 16K entry");
    lookup(36'h0_000A_4000, fixKind(17), "R4 mid 16K entry");
    lookup(36'h0_000B_FFFF, fixKind(23), "R4 last 16K entry");
    lookup(36'h0_000C_0000, fixKind(24), "R4 first 4K entry");
    lookup(36'h0_000F_FFFF, fixKind(87), "R4 last 4K entry");
    lookup(36'h0_0010_0000, WP,          "R5 first address above table");
  endtask

  task automatic tVariable();
    writeReg(8'h20, 64'h0_4000_0F01);
    writeReg(8'h21, 64'hF_C000_0800);
    lookup(36'h0_4000_0000, WC, "R6 range start hit");
    lookup(36'h0_7FFF_FFFF, WC, "R6 range end hit");
    lookup(36'h0_8000_0000, WP, "R6 above range misses");
    lookup(36'h0_3FFF_FFFF, WP, "R6 below range misses");
    writeReg(8'h22, 64'h0_4000_0000);
    writeReg(8'h23, 64'hF_C000_0000);
    lookup(36'h0_4000_0000, WC, "R6 invalid range ignored");
  endtask

  task automatic tMerge();
    writeReg(8'h24, 64'h0_4000_0004);
    writeReg(8'h25, 64'hF_FFF0_0800);
    lookup(36'h0_4000_0000, UC, "R7 WC with WT gives UC");
    lookup(36'h0_4010_0000, WC, "R7 single hit outside overlap");
    writeReg(8'h20, 64'h0_4000_0006);
    lookup(36'h0_4000_0000, WT, "R7 WB with WT gives WT");
    writeReg(8'h26, 64'h0_4000_0000);
    writeReg(8'h27, 64'hF_FFFF_F800);
    lookup(36'h0_4000_0000, UC, "R7 UC hit wins");
    lookup(36'h0_4000_1000, WT, "R7 outside UC page");
    writeReg(8'h24, 64'h0_4000_0006);
    lookup(36'h0_4000_1000, WB, "R7 identical types kept");
    writeReg(8'h28, 64'h0_0000_0000);
    writeReg(8'h29, 64'hF_C000_0800);
    lookup(36'h0_0000_0000, fixKind(0), "R4 fixed table beats variable hit");
    lookup(36'h0_0010_0000, UC, "R6 variable hit above first megabyte");
  endtask

  task automatic tEnables();
    writeReg(8'h00, 64'h405);
    lookup(36'h0_4000_0000, WP, "R8 variable disabled gives default");
    lookup(36'h0_000F_F000, fixKind(87), "R4 fixed still active");
    writeReg(8'h00, 64'h005);
    lookup(36'h0_0000_0000, 8'hFF, "R2 both enables clear");
  endtask

  task automatic tUpper();
    writeReg(8'h00, 64'h805);
    writeReg(8'h01, 64'h2_007F_FFFF);
    lookup(36'h1_0000_0000, WB, "R9 promoted at 4G");
    lookup(36'h1_FFFF_F000, WB, "R9 promoted just below boundary");
    lookup(36'h2_0000_0000, WP, "R9 boundary itself not promoted");
    lookup(36'h0_FFFF_F000, WP, "R9 below 4G not promoted");
    writeReg(8'h2A, 64'h1_0000_0004);
    writeReg(8'h2B, 64'hF_FFFF_F800);
    lookup(36'h1_0000_0000, WB, "R9 single hit promoted");
    writeReg(8'h2C, 64'h1_0000_0001);
    writeReg(8'h2D, 64'hF_FFFF_F800);
    lookup(36'h1_0000_0000, UC, "R9 multi-hit conflict stays UC");
  endtask

  task automatic tSameCycle();
    @(negedge clk);
    wrEn = 1'b1; wrSel = 8'h00; wrData = 64'h806;
    reqValid = 1'b1; reqAddr = 36'h3_0000_0000;
    @(negedge clk);
    wrEn = 1'b0; reqValid = 1'b0;
    check("R3 same-cycle lookup valid", 64'(rspValid), 64'd1);
    check("R3 same-cycle lookup sees old default", 64'(rspType), 64'(WP));
    lookup(36'h3_0000_0000, WB, "R3 next lookup sees new default");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tDefaultAndHold();
    tFixed();
    tVariable();
    tMerge();
    tEnables();
    tUpper();
    tSameCycle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule